// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits next to a small processor core and decides when the core must leave its program to serve an interrupt, and at which of two entry addresses it must start. Each request line has its own enable bit and its own priority bit, so any source can be routed to the urgent level or the background level. Each level also has its own global enable. The controller records which levels are in service, so that urgent work can cut into a background handler. Background work never cuts into anything.

At the moment of entry the controller copies the core's working, status and bank-select registers into a one-deep fast store. A return command carries a flag that asks for those three values to be handed back to the core. An interrupt return closes the innermost active level. A plain subroutine return leaves the service state as it is. A subroutine call with the fast flag set may also fill the store. The store has only one entry, so a nested urgent entry replaces the background snapshot.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When `take_o` is high, `vec_o` is 0x0008 if `lvl_o` is 1 (urgent level) and 0x0018 if `lvl_o` is 0 (background level).
- R2: Source i requests only while both `irq_req_i[i]` and `irq_en_i[i]` are 1. `irq_hi_i[i]`=1 places it at the urgent level and 0 at the background level.
- R3: The urgent level is entered only while `gie_hi_i` is 1, and the background level only while `gie_lo_i` is 1.
- R4: When both levels request in the same cycle, the urgent level is taken. `take_o` pulses for one cycle, one clock after the request is seen.
- R5: An urgent request is taken while a background handler is active. `lo_busy_o` stays 1 across the nested service.
- R6: A background request is not taken while either level is busy. An urgent request is not taken while the urgent level is busy.
- R7: On entry the current `wreg_i`, `stat_i` and `bsr_i` values are copied into the fast store. The copies appear on `wreg_o`, `stat_o` and `bsr_o` in the same cycle as `take_o`.
- R8: `ret_cmd_i` with `ret_irq_i`=1 clears the urgent busy flag if it is set, and otherwise clears the background flag. This reopens that level. One clock later `rest_o` equals `ret_fast_i`, and the store keeps its value.
- R9: An urgent entry during background service overwrites the fast store with the urgent-time register values.
- R10: `call_fast_i` copies the registers into the store. `ret_cmd_i` with `ret_irq_i`=0 pulses `rest_o` when `ret_fast_i` is set and leaves both busy flags unchanged.
- R11: No level is entered in a cycle where `ret_cmd_i` or `call_fast_i` is high. A request that is still present is taken on the next cycle.
- R12: After reset, `take_o`, `rest_o`, both busy flags and the fast store are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | NSRC | Request line per source |
| irq_en_i | input | NSRC | Enable per source |
| irq_hi_i | input | NSRC | Priority per source, 1 = urgent |
| gie_hi_i | input | 1 | Global enable, urgent level |
| gie_lo_i | input | 1 | Global enable, background level |
| wreg_i | input | DW | Core working register |
| stat_i | input | DW | Core status register |
| bsr_i | input | DW | Core bank-select register |
| call_fast_i | input | 1 | Call with fast save |
| ret_cmd_i | input | 1 | Return command |
| ret_irq_i | input | 1 | Return is from interrupt |
| ret_fast_i | input | 1 | Restore from fast store |
| take_o | output | 1 | Vector now |
| vec_o | output | AW | Entry address |
| lvl_o | output | 1 | Level taken, 1 = urgent |
| hi_busy_o | output | 1 | Urgent level in service |
| lo_busy_o | output | 1 | Background level in service |
| rest_o | output | 1 | Restore strobe |
| wreg_o | output | DW | Stored working register |
| stat_o | output | DW | Stored status register |
| bsr_o | output | DW | Stored bank-select register |

## Verification
Every result is registered and arrives exactly one clock after the inputs that cause it. This applies to `take_o`, the vector and level, the busy flags, the store contents and `rest_o`. The bench drives inputs on the falling edge and samples each result at the next falling edge, one rising edge later. A sweep covers all request, enable and priority patterns of four sources from the idle state, and each outcome is computed arithmetically. Directed sequences then check nesting, masking, command suppression and store overwrite cycle by cycle.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
    typedef struct packed {
        logic hi_busy;
        logic lo_busy;
        logic take;
        logic lvl;
        logic rest;
    } ctl_t;
endpackage

// File: rtl/irq_src_reduce.sv
module irq_src_reduce #(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] hi_i,
    output logic            any_hi_o,
    output logic            any_lo_o
);
    logic [NSRC-1:0] hot_hi;
    logic [NSRC-1:0] hot_lo;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hot_hi[i] = req_i[i] & en_i[i] &  hi_i[i];
        assign hot_lo[i] = req_i[i] & en_i[i] & ~hi_i[i];
    end

    assign any_hi_o = |hot_hi;
    assign any_lo_o = |hot_lo;
endmodule

// File: rtl/irq_fast_store.sv
module irq_fast_store #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [DW-1:0] wreg_i,
    input  logic [DW-1:0] stat_i,
    input  logic [DW-1:0] bsr_i,
    output logic [DW-1:0] wreg_o,
    output logic [DW-1:0] stat_o,
    output logic [DW-1:0] bsr_o
);
    typedef struct packed {
        logic [DW-1:0] w;
        logic [DW-1:0] s;
        logic [DW-1:0] b;
    } snap_t;

    snap_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (cap_i) begin
            snap_d.w = wreg_i;
            snap_d.s = stat_i;
            snap_d.b = bsr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign wreg_o = snap_q.w;
    assign stat_o = snap_q.s;
    assign bsr_o  = snap_q.b;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_lvl_pkg::*;
#(
    parameter int            NSRC   = 4,
    parameter int            DW     = 8,
    parameter int            AW     = 16,
    parameter logic [AW-1:0] HI_VEC = 16'h0008,
    parameter logic [AW-1:0] LO_VEC = 16'h0018
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req_i,
    input  logic [NSRC-1:0] irq_en_i,
    input  logic [NSRC-1:0] irq_hi_i,
    input  logic            gie_hi_i,
    input  logic            gie_lo_i,
    input  logic [DW-1:0]   wreg_i,
    input  logic [DW-1:0]   stat_i,
    input  logic [DW-1:0]   bsr_i,
    input  logic            call_fast_i,
    input  logic            ret_cmd_i,
    input  logic            ret_irq_i,
    input  logic            ret_fast_i,
    output logic            take_o,
    output logic [AW-1:0]   vec_o,
    output logic            lvl_o,
    output logic            hi_busy_o,
    output logic            lo_busy_o,
    output logic            rest_o,
    output logic [DW-1:0]   wreg_o,
    output logic [DW-1:0]   stat_o,
    output logic [DW-1:0]   bsr_o
);
    logic any_hi, any_lo;
    logic cmd_busy, want_hi, want_lo, cap;
    ctl_t ctl_d, ctl_q;

    irq_src_reduce #(.NSRC(NSRC)) reduce_i (
        .req_i    (irq_req_i),
        .en_i     (irq_en_i),
        .hi_i     (irq_hi_i),
        .any_hi_o (any_hi),
        .any_lo_o (any_lo)
    );

    always_comb begin
        cmd_busy = ret_cmd_i | call_fast_i;
        want_hi  = any_hi & gie_hi_i & ~ctl_q.hi_busy & ~cmd_busy;
        want_lo  = any_lo & gie_lo_i & ~ctl_q.hi_busy & ~ctl_q.lo_busy & ~cmd_busy;
        cap      = want_hi | want_lo | call_fast_i;

        ctl_d      = ctl_q;
        ctl_d.take = 1'b0;
        ctl_d.rest = 1'b0;
        if (want_hi) begin
            ctl_d.take    = 1'b1;
            ctl_d.lvl     = 1'b1;
            ctl_d.hi_busy = 1'b1;
        end else if (want_lo) begin
            ctl_d.take    = 1'b1;
            ctl_d.lvl     = 1'b0;
            ctl_d.lo_busy = 1'b1;
        end
        if (ret_cmd_i) begin
            ctl_d.rest = ret_fast_i;
            if (ret_irq_i) begin
                if (ctl_q.hi_busy) ctl_d.hi_busy = 1'b0;
                else               ctl_d.lo_busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    irq_fast_store #(.DW(DW)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .wreg_i (wreg_i),
        .stat_i (stat_i),
        .bsr_i  (bsr_i),
        .wreg_o (wreg_o),
        .stat_o (stat_o),
        .bsr_o  (bsr_o)
    );

    assign take_o    = ctl_q.take;
    assign lvl_o     = ctl_q.lvl;
    assign vec_o     = ctl_q.lvl ? HI_VEC : LO_VEC;
    assign hi_busy_o = ctl_q.hi_busy;
    assign lo_busy_o = ctl_q.lo_busy;
    assign rest_o    = ctl_q.rest;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int            DW     = 8,
    parameter int            AW     = 16,
    parameter logic [AW-1:0] HI_VEC = 16'h0008,
    parameter logic [AW-1:0] LO_VEC = 16'h0018
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gie_hi_i,
    input logic [DW-1:0] wreg_i,
    input logic          ret_cmd_i,
    input logic          ret_fast_i,
    input logic          take_o,
    input logic [AW-1:0] vec_o,
    input logic          lvl_o,
    input logic          hi_busy_o,
    input logic          lo_busy_o,
    input logic          rest_o,
    input logic [DW-1:0] wreg_o
);
    AST_HI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && lvl_o |-> vec_o == HI_VEC); // R1
    AST_LO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && !lvl_o |-> vec_o == LO_VEC && !hi_busy_o); // R6
    AST_LO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_busy_o) |-> take_o && !lvl_o); // R4
    AST_HI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_busy_o) |-> $past(gie_hi_i) && take_o); // R3
    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> wreg_o == $past(wreg_i)); // R7
    AST_REST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rest_o |-> $past(ret_cmd_i && ret_fast_i)); // R8
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .DW(DW), .AW(AW), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gie_hi_i   (gie_hi_i),
    .wreg_i     (wreg_i),
    .ret_cmd_i  (ret_cmd_i),
    .ret_fast_i (ret_fast_i),
    .take_o     (take_o),
    .vec_o      (vec_o),
    .lvl_o      (lvl_o),
    .hi_busy_o  (hi_busy_o),
    .lo_busy_o  (lo_busy_o),
    .rest_o     (rest_o),
    .wreg_o     (wreg_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
    localparam int NSRC = 4;
    localparam int DW   = 8;
    localparam int AW   = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] irq_req, irq_en, irq_hi;
    logic            gie_hi, gie_lo;
    logic [DW-1:0]   wreg, stat, bsr;
    logic            call_fast, ret_cmd, ret_irq, ret_fast;
    logic            take, lvl, hi_busy, lo_busy, rest;
    logic [AW-1:0]   vec;
    logic [DW-1:0]   wreg_s, stat_s, bsr_s;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .irq_req_i(irq_req), .irq_en_i(irq_en), .irq_hi_i(irq_hi),
        .gie_hi_i(gie_hi), .gie_lo_i(gie_lo),
        .wreg_i(wreg), .stat_i(stat), .bsr_i(bsr),
        .call_fast_i(call_fast), .ret_cmd_i(ret_cmd),
        .ret_irq_i(ret_irq), .ret_fast_i(ret_fast),
        .take_o(take), .vec_o(vec), .lvl_o(lvl),
        .hi_busy_o(hi_busy), .lo_busy_o(lo_busy), .rest_o(rest),
        .wreg_o(wreg_s), .stat_o(stat_s), .bsr_o(bsr_s)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; irq_en = '0; irq_hi = '0;
        gie_hi = 1'b1; gie_lo = 1'b1; wreg = '0; stat = '0; bsr = '0;
        call_fast = 0; ret_cmd = 0; ret_irq = 0; ret_fast = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset ctl", {take, rest, hi_busy, lo_busy}, 0);
        chk("R12 reset store", {wreg_s, stat_s, bsr_s}, 0);

        // Preemption and store overwrite
        irq_en = 4'b0011; irq_hi = 4'b0010;
        irq_req = 4'b0001; wreg = 8'h11; stat = 8'h12; bsr = 8'h13;
        step();
        chk("R1 lo take", {take, lvl, vec}, {1'b1, 1'b0, 16'h0018});
        chk("R7 lo snapshot", {wreg_s, stat_s, bsr_s}, 24'h111213);
        irq_req = 4'b0000;
        step();
        chk("R4 single pulse", take, 0);
        irq_req = 4'b0010; wreg = 8'h22; stat = 8'h23; bsr = 8'h24;
        step();
        chk("R5 preempt", {take, lvl, vec, hi_busy, lo_busy}, {1'b1, 1'b1, 16'h0008, 2'b11});
        chk("R9 overwrite", {wreg_s, stat_s, bsr_s}, 24'h222324);
        irq_req = 4'b0001;
        step();
        chk("R6 lo waits", take, 0);
        irq_req = 4'b0011;
        step();
        chk("R6 hi waits", take, 0);
        irq_req = 4'b0000;
        ret_cmd = 1; ret_irq = 0; ret_fast = 1;
        step();
        chk("R10 plain return", {rest, hi_busy, lo_busy}, 3'b111);
        ret_irq = 1;
        step();
        chk("R8 exit hi", {rest, hi_busy, lo_busy, wreg_s}, {3'b101, 8'h22});
        ret_cmd = 0;
        step();
        chk("R8 rest pulse", rest, 0);
        ret_cmd = 1; ret_fast = 0;
        step();
        chk("R8 exit lo no restore", {rest, hi_busy, lo_busy}, 3'b000);
        ret_cmd = 0;

        // Global enables
        gie_hi = 0; irq_req = 4'b0010;
        step(); step();
        chk("R3 hi masked", {take, hi_busy}, 0);
        gie_hi = 1;
        step();
        chk("R3 hi unmasked", {take, lvl}, 2'b11);
        irq_req = 0; ret_cmd = 1; ret_irq = 1;
        step();
        ret_cmd = 0;
        gie_lo = 0; irq_req = 4'b0001;
        step(); step();
        chk("R3 lo masked", {take, lo_busy}, 0);
        gie_lo = 1; irq_req = 0;

        // Commands suppress entry; call fills store
        irq_req = 4'b0010; call_fast = 1; wreg = 8'h33; stat = 8'h34; bsr = 8'h35;
        step();
        chk("R11 suppressed", {take, hi_busy}, 0);
        chk("R10 call save", {wreg_s, stat_s, bsr_s}, 24'h333435);
        call_fast = 0; wreg = 8'h44; stat = 8'h45; bsr = 8'h46;
        step();
        chk("R11 taken next", {take, lvl, wreg_s}, {2'b11, 8'h44});
        irq_req = 0; ret_cmd = 1; ret_irq = 1; ret_fast = 0;
        step();
        ret_cmd = 0;
        step();
        chk("R8 idle again", {hi_busy, lo_busy}, 0);

        // Exhaustive sweep from idle
        for (int c = 0; c < 4096; c++) begin
            logic ah, al;
            irq_req = c[3:0]; irq_en = c[7:4]; irq_hi = c[11:8];
            ah = |(irq_req & irq_en & irq_hi);
            al = |(irq_req & irq_en & ~irq_hi);
            step();
            if (ah)
                chk("R2 R4 sweep hi", {take, lvl, vec}, {2'b11, 16'h0008});
            else if (al)
                chk("R2 sweep lo", {take, lvl, vec}, {2'b10, 16'h0018});
            else
                chk("R2 sweep none", take, 0);
            irq_req = 0;
            if (ah || al) begin
                ret_cmd = 1; ret_irq = 1; ret_fast = 0;
                step();
                ret_cmd = 0;
            end
        end
        step();
        chk("R12 final idle", {take, hi_busy, lo_busy}, 0);
        finish_run();
    end
endmodule